// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle in which `valid_i` is high, it takes an operation code, a register byte, an operand byte and the four incoming status flags: negative, zero, carry and overflow. It computes a result byte and four new flags. Both are captured in output registers, so they appear one cycle later, and `done_o` marks that cycle.

Every operation class has its own flag rule. Subtract and compare run through the adder with the operand inverted. Carry therefore means "no borrow" for both. Subtract takes the inverted carry-in as its borrow. Compare forces the borrow off. Any flag that an operation does not define is copied from its input, so the enclosing processor can keep its flag register outside this block. Decimal arithmetic is not provided.

Top module: `alu8_flags`

## Requirements
- R1: Each cycle with `valid_i` high is followed by exactly one cycle with `done_o` high. In that cycle, `res_o` and the flags show the result of the captured operation.
- R2: Code 0 (add) gives `res_o` = reg + operand + carry-in modulo 256, and carry = bit 8 of the 9-bit sum.
- R3: For add and subtract, overflow is set exactly when the two signed inputs (for subtract, the register and the inverted operand) share a sign and the result's sign differs from it.
- R4: Code 1 (subtract) gives reg − operand − (1 − carry-in) modulo 256, with carry set when no borrow occurs.
- R5: Codes 2 (AND), 3 (OR) and 4 (XOR) combine register and operand bitwise. Negative is set to result bit 7 and zero to (result == 0). Carry and overflow pass through unchanged.
- R6: Codes 5 (increment) and 6 (decrement) add or subtract one with wraparound. Negative and zero follow the result. Carry and overflow pass through.
- R7: Code 7 (shift left) moves old bit 7 into carry and fills bit 0 with zero. Code 8 (shift right) moves old bit 0 into carry and fills bit 7 with zero. Negative and zero follow the result. Overflow passes through.
- R8: Code 9 (rotate left) puts carry-in into bit 0 and old bit 7 into carry. Code 10 (rotate right) puts carry-in into bit 7 and old bit 0 into carry. Overflow passes through.
- R9: Code 11 (compare) returns the register byte unchanged. Zero is set when register == operand, carry when register >= operand (unsigned), and negative is bit 7 of register − operand. Overflow passes through.
- R10: Code 12 (load) returns the operand byte. Negative and zero follow it. Carry and overflow pass through.
- R11: Codes 13 to 15 return the register byte and pass all four flags through unchanged.
- R12: After reset, `res_o`, all flags and `done_o` are zero. While `valid_i` is low, `res_o` and the flags hold and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| reg_i | input | 8 | Register or accumulator byte |
| opnd_i | input | 8 | Operand byte |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| res_o | output | 8 | Registered result byte |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |
| v_o | output | 1 | Registered overflow flag |
| done_o | output | 1 | Result valid this cycle |

## Verification
Two things can happen in the same cycle: a new operation is captured while the previous result is still on the outputs. The bench issues operations on consecutive cycles and changes the incoming flags every time, so a stale flag or a late update shows up as a mismatch against the queued expectation. Idle gaps are placed between bursts to confirm that outputs hold when nothing is issued. Sign and carry boundaries (0x7F/0x80, 0x00/0xFF, equal compare operands) are chosen to exercise each flag rule.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] opnd_i,
  input  logic         n_i,
  input  logic         z_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         done_o
);
  localparam int M = W - 1;
  localparam logic [3:0] OP_ADC = 4'd0, OP_SBC = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_ASL = 4'd7,
                         OP_LSR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_CMP = 4'd11,
                         OP_LD  = 4'd12;

  logic         sub_path, cin_eff, ovf;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  assign sub_path = (op_i == OP_SBC) || (op_i == OP_CMP);
  assign b_eff    = sub_path ? ~opnd_i : opnd_i;
  assign cin_eff  = (op_i == OP_CMP) ? 1'b1 : c_i;
  assign sum      = {1'b0, reg_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
  assign ovf      = (reg_i[M] == b_eff[M]) && (sum[M] != reg_i[M]);

  logic [W-1:0] r;
  logic         nn, nz, nc, nv, upd;

  always_comb begin
    r   = reg_i;
    nn  = n_i;
    nz  = z_i;
    nc  = c_i;
    nv  = v_i;
    upd = 1'b1;
    case (op_i)
      OP_ADC, OP_SBC: begin
        r  = sum[M:0];
        nc = sum[W];
        nv = ovf;
      end
      OP_AND: r = reg_i & opnd_i;
      OP_OR:  r = reg_i | opnd_i;
      OP_XOR: r = reg_i ^ opnd_i;
      OP_INC: r = reg_i + {{M{1'b0}}, 1'b1};
      OP_DEC: r = reg_i - {{M{1'b0}}, 1'b1};
      OP_ASL: begin
        r  = {reg_i[M-1:0], 1'b0};
        nc = reg_i[M];
      end
      OP_LSR: begin
        r  = {1'b0, reg_i[M:1]};
        nc = reg_i[0];
      end
      OP_ROL: begin
        r  = {reg_i[M-1:0], c_i};
        nc = reg_i[M];
      end
      OP_ROR: begin
        r  = {c_i, reg_i[M:1]};
        nc = reg_i[0];
      end
      OP_CMP: begin
        upd = 1'b0;
        nn  = sum[M];
        nz  = (reg_i == opnd_i);
        nc  = sum[W];
      end
      OP_LD:  r = opnd_i;
      default: upd = 1'b0;
    endcase
    if (upd) begin
      nn = r[M];
      nz = (r == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o  <= '0;
      n_o    <= 1'b0;
      z_o    <= 1'b0;
      c_o    <= 1'b0;
      v_o    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        res_o <= r;
        n_o   <= nn;
        z_o   <= nz;
        c_o   <= nc;
        v_o   <= nv;
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] opnd_i,
  input logic         n_i,
  input logic         z_i,
  input logic         c_i,
  input logic         v_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         done_o
);
  logic [W:0] add_ref;
  logic       is_logic, is_spare;
  assign add_ref  = {1'b0, reg_i} + {1'b0, opnd_i} + {{W{1'b0}}, c_i};
  assign is_logic = (op_i == 4'd2) || (op_i == 4'd3) || (op_i == 4'd4);
  assign is_spare = (op_i >= 4'd13);

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!done_o && $stable(res_o) && $stable(n_o) && $stable(z_o)
                  && $stable(c_o) && $stable(v_o))); // R12
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd0) |=> ({c_o, res_o} == $past(add_ref))); // R2
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_logic) |=> (c_o == $past(c_i) && v_o == $past(v_i))); // R5
  AST_CMP_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd11) |=> (c_o == $past(reg_i >= opnd_i) && res_o == $past(reg_i))); // R9
  AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_spare) |=> ({n_o, z_o, c_o, v_o} == $past({n_i, z_i, c_i, v_i}))); // R11
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .reg_i(reg_i),
  .opnd_i(opnd_i), .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i), .res_o(res_o),
  .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .done_o(done_o)
);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] reg_i = '0, opnd_i = '0;
  logic       n_i = 1'b0, z_i = 1'b0, c_i = 1'b0, v_i = 1'b0;
  logic [7:0] res_o;
  logic       n_o, z_o, c_o, v_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [11:0] exp_q[$];
  string       req_q[$];
  logic [7:0]  last_res = '0;

  always #4 clk = ~clk;

  alu8_flags u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .reg_i(reg_i),
    .opnd_i(opnd_i), .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i), .res_o(res_o),
    .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got res=%h nzcv=%b exp res=%h nzcv=%b",
               req, got[11:4], got[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic issue(input string req, input int op, input int a, input int b,
                       input bit n, input bit z, input bit c, input bit v);
    int s, r;
    bit en, ez, ec, ev, nz;
    @(negedge clk);
    valid_i = 1'b1; op_i = op[3:0]; reg_i = a[7:0]; opnd_i = b[7:0];
    n_i = n; z_i = z; c_i = c; v_i = v;
    r = a; en = n; ez = z; ec = c; ev = v; nz = 1'b1;
    case (op)
      0: begin s = a + b + int'(c); r = s & 255; ec = s > 255;
               ev = (((a ^ r) & (b ^ r)) & 128) != 0; end
      1: begin s = a - b - (1 - int'(c)); r = s & 255; ec = s >= 0;
               ev = (((a ^ b) & (a ^ r)) & 128) != 0; end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (a + 1) & 255;
      6: r = (a + 255) & 255;
      7: begin r = (a * 2) & 255; ec = a >= 128; end
      8: begin r = a / 2; ec = (a % 2) == 1; end
      9: begin r = ((a * 2) & 255) + int'(c); ec = a >= 128; end
      10: begin r = a / 2 + (c ? 128 : 0); ec = (a % 2) == 1; end
      11: begin nz = 1'b0; en = (((a - b) & 255) >= 128); ez = (a == b); ec = (a >= b); end
      12: r = b;
      default: nz = 1'b0;
    endcase
    if (nz) begin en = r >= 128; ez = (r == 0); end
    exp_q.push_back({r[7:0], en, ez, ec, ev});
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected done", {res_o, n_o, z_o, c_o, v_o}, 12'hxxx);
      end else begin
        logic [11:0] e;
        string rq;
        e = exp_q.pop_front();
        rq = req_q.pop_front();
        check(rq, {res_o, n_o, z_o, c_o, v_o}, e);
        last_res = e[11:4];
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset state", {res_o, n_o, z_o, c_o, v_o}, 12'h000);
    checks++;
    if (done_o !== 1'b0) begin errors++; $display("FAIL R12 done after reset got %b exp 0", done_o); end
    rst_n = 1'b1;
    // back-to-back bursts with changing incoming flags
    issue("R2 R3 add signed overflow", 0, 8'h50, 8'h50, 0, 0, 0, 0);
    issue("R2 add carry wrap to zero", 0, 8'hFF, 8'h00, 1, 0, 1, 1);
    issue("R3 add both negative", 0, 8'h80, 8'h80, 0, 1, 0, 0);
    issue("R2 add plain", 0, 8'h12, 8'h34, 1, 1, 1, 1);
    issue("R4 R3 sub overflow", 1, 8'h50, 8'hB0, 0, 0, 1, 0);
    issue("R4 sub with borrow in", 1, 8'h05, 8'h05, 0, 0, 0, 1);
    issue("R4 sub no borrow", 1, 8'h05, 8'h03, 1, 1, 1, 1);
    issue("R3 sub 80-01", 1, 8'h80, 8'h01, 0, 0, 1, 0);
    idle(3);
    checks++;
    if (res_o !== last_res || done_o !== 1'b0) begin
      errors++; $display("FAIL R12 hold got res=%h done=%b exp res=%h done=0", res_o, done_o, last_res);
    end
    issue("R5 and", 2, 8'hF0, 8'h0F, 1, 0, 1, 1);
    issue("R5 or", 3, 8'h80, 8'h01, 0, 1, 0, 1);
    issue("R5 xor zero", 4, 8'hA5, 8'hA5, 1, 0, 1, 0);
    issue("R6 inc wrap", 5, 8'hFF, 8'h00, 0, 0, 1, 1);
    issue("R6 inc to 80", 5, 8'h7F, 8'h00, 0, 1, 0, 0);
    issue("R6 dec wrap", 6, 8'h00, 8'h00, 0, 1, 1, 0);
    issue("R6 dec to zero", 6, 8'h01, 8'h00, 1, 0, 0, 1);
    issue("R7 shift left", 7, 8'hC1, 8'h00, 0, 0, 0, 1);
    issue("R7 shift left zero", 7, 8'h80, 8'h00, 1, 0, 0, 0);
    issue("R7 shift right", 8, 8'h03, 8'h00, 1, 0, 0, 1);
    issue("R8 rotate left", 9, 8'h80, 8'h00, 0, 0, 1, 0);
    issue("R8 rotate right", 10, 8'h01, 8'h00, 0, 0, 1, 1);
    issue("R8 rotate right no carry", 10, 8'h02, 8'h00, 1, 1, 0, 0);
    issue("R9 compare equal", 11, 8'h42, 8'h42, 1, 0, 0, 1);
    issue("R9 compare less", 11, 8'h10, 8'h20, 0, 1, 1, 0);
    issue("R9 compare greater", 11, 8'hF0, 8'h01, 1, 1, 0, 1);
    issue("R10 load negative", 12, 8'h00, 8'h9C, 0, 1, 1, 1);
    issue("R10 load zero", 12, 8'h55, 8'h00, 1, 0, 0, 0);
    issue("R11 spare 13", 13, 8'h3C, 8'hFF, 1, 0, 1, 0);
    issue("R11 spare 15", 15, 8'h00, 8'h11, 0, 1, 0, 1);
    idle(4);
    checks++;
    if (exp_q.size() != 0 || res_o !== last_res) begin
      errors++; $display("FAIL R1 R12 pending=%0d res=%h exp pending=0 res=%h", exp_q.size(), res_o, last_res);
    end
    finish_run();
  end
endmodule